// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block keeps the isochronous cycle time of a serial bus link layer node. A 32-bit timer, advanced once per clock of a 24.576 MHz timebase, is split into a seconds field, a cycle count and a cycle offset. A full sweep of the offset marks one 125 µs isochronous cycle, so cycles begin at 8 kHz. Each new cycle raises a one-clock cycle tick.

The node either acts as cycle master or follows one. As master, it raises a level request toward the packet transmitter whenever a new cycle begins, asking for a cycle start packet to be queued. The request stays high until it is acknowledged. The master may take its cycle edge from the internal offset wrap, or from an external reference that it synchronizes. As follower, the node overwrites its timer with the value carried in every received cycle start packet, which keeps it aligned with the master.

Top module: `cycle_timer_top`

## Requirements
- R1: `cycle_time` holds seconds in bits 31:25, cycle count in bits 24:12 and cycle offset in bits 11:0. On each clock with no other event, the offset increases by one.
- R2: An offset of 3071 rolls to 0 on the next clock and advances the count. A count of 7999 rolls to 0 and advances the seconds. Seconds roll from 127 to 0.
- R3: `cycle_tick` is high for exactly the clock in which the timer shows the first offset of a new cycle, whether that cycle was started by the internal wrap or by the external edge. A load never raises it.
- R4: With `master_en` and `ext_sel` both high, the offset advances but holds at 3071 rather than rolling over. A rising edge on `ext_ref` passes a two-flop synchronizer, and on the third rising clock edge after it, the offset becomes 0 and the count advances. Edges have no effect in any other mode.
- R5: With `master_en` low, a high `rx_cs_valid` writes `rx_cs_data` into the timer at the next clock edge, in place of that clock's increment. Loaded fields are expected to lie within their ranges. With `master_en` high, the strobe is ignored.
- R6: With `master_en` high, `cs_req` rises one clock after `cycle_tick` and stays high until a clock on which `tx_ack` is high. A tick arriving while a request is pending leaves a single pending request. `cs_req` falls on the clock after `master_en` goes low.
- R7: Reset, active low, clears `cycle_time`, `cycle_tick` and `cs_req` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz timebase |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_en | input | 1 | Node acts as cycle master |
| ext_sel | input | 1 | Master takes its cycle edge from `ext_ref` |
| ext_ref | input | 1 | Asynchronous external cycle reference |
| rx_cs_valid | input | 1 | Strobe for a received cycle start value |
| rx_cs_data | input | 32 | Timer value carried in the received cycle start packet |
| tx_ack | input | 1 | Transmitter accepted the pending request |
| cycle_time | output | 32 | Current timer value |
| cycle_tick | output | 1 | Pulse marking the start of a new cycle |
| cs_req | output | 1 | Pending request to queue a cycle start packet |

## Verification
The timer and `cycle_tick` settle one clock after the inputs that cause them. An external edge reaches the timer on the third clock edge after `ext_ref` rises. `cs_req` lags its tick by one more clock, and it falls one clock after `tx_ack`. The bench drives inputs on falling edges and advances a reference model on every rising edge. It compares all outputs a quarter period after the rising edge, so each result is sampled in the cycle it becomes due. The directed sequences count falling edges out to exactly those latencies.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
    localparam int SEC_W  = 7;
    localparam int CNT_W  = 13;
    localparam int OFF_W  = 12;
    localparam int TIME_W = SEC_W + CNT_W + OFF_W;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CNT_W-1:0] cnt;
        logic [OFF_W-1:0] off;
    } cyc_time_t;
endpackage

// File: rtl/cyc_ref_sync.sv
module cyc_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    localparam int LAST = STAGES;

    logic [LAST:0] shift_d, shift_q;

    always_comb begin
        shift_d = {shift_q[LAST-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign rise_o = shift_q[LAST-1] & ~shift_q[LAST];
endmodule

// File: rtl/cyc_time_core.sv
module cyc_time_core
    import cyc_timer_pkg::*;
#(
    parameter int OFFSET_LAST = 3071,
    parameter int COUNT_LAST  = 7999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en_i,
    input  logic              ext_sel_i,
    input  logic              ext_rise_i,
    input  logic              load_valid_i,
    input  logic [TIME_W-1:0] load_data_i,
    output logic [TIME_W-1:0] time_o,
    output logic              tick_o
);
    localparam logic [OFF_W-1:0] OFF_LAST_V = OFF_W'(OFFSET_LAST);
    localparam logic [CNT_W-1:0] CNT_LAST_V = CNT_W'(COUNT_LAST);

    typedef struct packed {
        cyc_time_t tm;
        logic      tick;
    } core_st_t;

    core_st_t st_d, st_q;

    // Start a new cycle: offset back to zero, count (and seconds) forward
    function automatic cyc_time_t new_cycle(cyc_time_t t);
        cyc_time_t r;
        r     = t;
        r.off = '0;
        if (t.cnt >= CNT_LAST_V) begin
            r.cnt = '0;
            r.sec = t.sec + 1'b1;
        end else begin
            r.cnt = t.cnt + 1'b1;
        end
        return r;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (load_valid_i && !master_en_i) begin
            st_d.tm = cyc_time_t'(load_data_i);
        end else if (master_en_i && ext_sel_i) begin
            if (ext_rise_i) begin
                st_d.tm   = new_cycle(st_q.tm);
                st_d.tick = 1'b1;
            end else if (st_q.tm.off < OFF_LAST_V) begin
                st_d.tm.off = st_q.tm.off + 1'b1;
            end
        end else if (st_q.tm.off >= OFF_LAST_V) begin
            st_d.tm   = new_cycle(st_q.tm);
            st_d.tick = 1'b1;
        end else begin
            st_d.tm.off = st_q.tm.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = st_q.tm;
    assign tick_o = st_q.tick;
endmodule

// File: rtl/cyc_start_req.sv
module cyc_start_req (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en_i,
    input  logic tick_i,
    input  logic ack_i,
    output logic req_o
);
    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = master_en_i & ((st_q.req & ~ack_i) | tick_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/cycle_timer_top.sv
module cycle_timer_top
    import cyc_timer_pkg::*;
#(
    parameter int OFFSET_LAST = 3071,
    parameter int COUNT_LAST  = 7999,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              ext_sel,
    input  logic              ext_ref,
    input  logic              rx_cs_valid,
    input  logic [TIME_W-1:0] rx_cs_data,
    input  logic              tx_ack,
    output logic [TIME_W-1:0] cycle_time,
    output logic              cycle_tick,
    output logic              cs_req
);
    logic ext_rise;

    cyc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_ref),
        .rise_o  (ext_rise)
    );

    cyc_time_core #(.OFFSET_LAST(OFFSET_LAST), .COUNT_LAST(COUNT_LAST)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_en_i  (master_en),
        .ext_sel_i    (ext_sel),
        .ext_rise_i   (ext_rise),
        .load_valid_i (rx_cs_valid),
        .load_data_i  (rx_cs_data),
        .time_o       (cycle_time),
        .tick_o       (cycle_tick)
    );

    cyc_start_req u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en_i (master_en),
        .tick_i      (cycle_tick),
        .ack_i       (tx_ack),
        .req_o       (cs_req)
    );
endmodule

// File: rtl/cycle_timer_chk.sv
module cycle_timer_chk #(
    parameter int OFFSET_LAST = 3071,
    parameter int COUNT_LAST  = 7999
) (
    input logic        clk,
    input logic        rst_n,
    input logic        master_en,
    input logic        ext_sel,
    input logic        rx_cs_valid,
    input logic [31:0] rx_cs_data,
    input logic        tx_ack,
    input logic [31:0] cycle_time,
    input logic        cycle_tick,
    input logic        cs_req
);
    AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cycle_time[11:0]) <= OFFSET_LAST); // R1
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cycle_time[24:12]) <= COUNT_LAST); // R2
    AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_tick |-> cycle_time[11:0] == 12'd0); // R3
    AST_FOLLOWER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cs_valid && !master_en) |=> cycle_time == $past(rx_cs_data)); // R5
    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && ext_sel && cycle_time[11:0] == 12'(OFFSET_LAST) && !cycle_tick)
        |=> (cycle_time[11:0] == 12'(OFFSET_LAST) || cycle_tick || !$past(ext_sel)
             || !$past(master_en))); // R4
    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_tick && master_en) |=> cs_req); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_req && !tx_ack && master_en) |=> cs_req); // R6
    AST_REQ_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !cs_req); // R6
endmodule

bind cycle_timer_top cycle_timer_chk #(
    .OFFSET_LAST(OFFSET_LAST),
    .COUNT_LAST (COUNT_LAST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en   (master_en),
    .ext_sel     (ext_sel),
    .rx_cs_valid (rx_cs_valid),
    .rx_cs_data  (rx_cs_data),
    .tx_ack      (tx_ack),
    .cycle_time  (cycle_time),
    .cycle_tick  (cycle_tick),
    .cs_req      (cs_req)
);

// File: tb/test_cycle_timer_top.sv
module test_cycle_timer_top;
    localparam int CLK_PERIOD = 40;
    localparam int RAND_CYCLES = 70000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0, ext_sel = 1'b0, ext_ref = 1'b0;
    logic        rx_cs_valid = 1'b0, tx_ack = 1'b0;
    logic [31:0] rx_cs_data = '0;
    logic [31:0] cycle_time;
    logic        cycle_tick, cs_req;

    int n_checks = 0;
    int n_errors = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cycle_timer_top i_cycle_timer_top (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .ext_sel(ext_sel),
        .ext_ref(ext_ref), .rx_cs_valid(rx_cs_valid), .rx_cs_data(rx_cs_data),
        .tx_ack(tx_ack), .cycle_time(cycle_time), .cycle_tick(cycle_tick),
        .cs_req(cs_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input int s, input int c, input int o);
        return {7'(s), 13'(c), 12'(o)};
    endfunction

    // R2: start of a new cycle from the field rules
    function automatic logic [31:0] next_cycle(input logic [31:0] t);
        logic [6:0] s = t[31:25];
        logic [12:0] c = t[24:12];
        if (c >= 13'd7999) begin c = '0; s = s + 7'd1; end
        else c = c + 13'd1;
        return {s, c, 12'd0};
    endfunction

    // Reference model
    logic [31:0] m_time;
    logic        m_tick, m_req;
    logic [2:0]  m_sync;
    string       m_tag;
    logic [31:0] nt;
    logic        ntick, rise;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time <= '0; m_tick <= 1'b0; m_req <= 1'b0; m_sync <= '0; m_tag <= "R7";
        end else begin
            rise  = m_sync[1] & ~m_sync[2];
            nt    = m_time;
            ntick = 1'b0;
            m_tag <= "R1";
            if (rx_cs_valid && !master_en) begin
                nt = rx_cs_data; m_tag <= "R5";
            end else if (master_en && ext_sel) begin
                m_tag <= "R4";
                if (rise) begin nt = next_cycle(m_time); ntick = 1'b1; end
                else if (m_time[11:0] < 12'd3071) nt = m_time + 32'd1;
            end else if (m_time[11:0] >= 12'd3071) begin
                nt = next_cycle(m_time); ntick = 1'b1; m_tag <= "R2";
            end else begin
                nt = m_time + 32'd1;
            end
            m_req  <= master_en & ((m_req & ~tx_ack) | m_tick);
            m_sync <= {m_sync[1:0], ext_ref};
            m_time <= nt;
            m_tick <= ntick;
        end
    end

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (model_on && rst_n) begin
            check(m_tag, cycle_time, m_time);
            check("R3 tick", {31'd0, cycle_tick}, {31'd0, m_tick});
            check("R6 req", {31'd0, cs_req}, {31'd0, m_req});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] t0;
        void'($urandom(32'h5EED));
        step(4);
        check("R7 time", cycle_time, 32'd0);
        check("R7 tick", {31'd0, cycle_tick}, 32'd0);
        check("R7 req", {31'd0, cs_req}, 32'd0);
        rst_n = 1'b1;
        model_on = 1'b1;
        step(5);
        check("R1 count up", cycle_time, mk(0, 0, 5));

        // Full wrap from follower load
        rx_cs_valid = 1'b1; rx_cs_data = mk(127, 7999, 3071);
        step(1); rx_cs_valid = 1'b0;
        check("R5 load", cycle_time, mk(127, 7999, 3071));
        step(1);
        check("R2 full wrap", cycle_time, 32'd0);
        check("R3 tick on wrap", {31'd0, cycle_tick}, 32'd1);
        rx_cs_valid = 1'b1; rx_cs_data = mk(3, 7999, 3071);
        step(1); rx_cs_valid = 1'b0;
        step(1);
        check("R2 count wrap", cycle_time, mk(4, 0, 0));

        // Master ignores the load strobe
        rx_cs_valid = 1'b1; rx_cs_data = mk(5, 10, 100);
        step(1);
        master_en = 1'b1; rx_cs_data = mk(9, 9, 9);
        step(1); rx_cs_valid = 1'b0;
        check("R5 ignored in master", cycle_time, mk(5, 10, 101));

        // External reference path
        ext_sel = 1'b1; ext_ref = 1'b0;
        step(4);
        t0 = cycle_time;
        ext_ref = 1'b1;
        step(2);
        check("R4 not yet", cycle_time, t0 + 32'd2);
        step(1);
        check("R4 ext edge", cycle_time, mk(5, 11, 0));
        check("R3 ext tick", {31'd0, cycle_tick}, 32'd1);
        step(1);
        check("R6 req raised", {31'd0, cs_req}, 32'd1);
        step(3100);
        check("R4 hold", cycle_time, mk(5, 11, 3071));
        check("R6 still pending", {31'd0, cs_req}, 32'd1);
        ext_ref = 1'b0; step(3); ext_ref = 1'b1; step(4);
        check("R6 single pending", {31'd0, cs_req}, 32'd1);
        tx_ack = 1'b1; step(1); tx_ack = 1'b0;
        check("R6 ack clears", {31'd0, cs_req}, 32'd0);

        // Random mix
        for (int i = 0; i < RAND_CYCLES; i++) begin
            @(negedge clk);
            if (i % 3000 == 0) begin
                master_en = 1'($urandom % 2);
                ext_sel   = 1'($urandom % 2);
            end
            if ($urandom % 40 == 0) ext_ref = ~ext_ref;
            tx_ack = ($urandom % 8 == 0);
            rx_cs_valid = ($urandom % 300 == 0);
            rx_cs_data = mk($urandom % 128,
                            ($urandom % 2) ? 7990 + $urandom % 10 : $urandom % 8000,
                            ($urandom % 2) ? 3060 + $urandom % 12 : $urandom % 3072);
        end

        // Reset in mid-run
        @(negedge clk); rst_n = 1'b0; model_on = 1'b0;
        step(2);
        check("R7 time mid", cycle_time, 32'd0);
        check("R7 req mid", {31'd0, cs_req}, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule